// File: doc/BRIEF.md
# System I/O and Security Control Register Block

This block is the register file behind the console's system I/O window. A bus-side agent presents a decoded I/O offset with a strobe, a write flag and 16-bit write data. On reads the block returns a registered word one cycle later. That word can be a status byte built from the region and model strap inputs, a byte captured from one of three peripheral ports, or the inverted bus-grant line of the sound coprocessor.

On writes the block does one of several things:
- It forwards a byte to a peripheral port as a one-cycle strobe.
- It drives the coprocessor bus request and its reset-release line.
- It records whether each half of a two-word unlock key was written exactly.
- It holds the flag that selects the cartridge instead of the boot ROM.

The peripherals themselves sit outside the block. Offsets are relative to the base of the I/O window, and address bit 0 plays no part in matching.

Top module: `sysio_regs`

## Requirements
- R1: During and after reset, and until written, rom_enable, video_unlocked, cop_busreq, cop_enable, rd_valid, port_data_we and port_ctrl_we are all 0.
- R2: A read of offset 0x0000 raises rd_valid and presents rd_data in the cycle after the request. rd_data[7] is strap_export, rd_data[6] is strap_pal, rd_data[5] is strap_no_exp, rd_data[4] is 0, rd_data[3:0] is strap_version and rd_data[15:8] is 0.
- R3: Reads of offsets 0x0002, 0x0004 and 0x0006 return, zero-extended, the byte of port 0, 1 or 2 from port_data_in (port n in bits [8n+7:8n]).
- R4: Reads of offsets 0x0008, 0x000A and 0x000C return, zero-extended, the byte of port 0, 1 or 2 from port_ctrl_in.
- R5: A write to a port data or control offset raises, for exactly the following cycle, the one bit of port_data_we or port_ctrl_we that belongs to that port, with port_wdata equal to req_wdata[7:0].
- R6: A read of offset 0x1100 returns bit 8 equal to the inverse of cop_grant, with all other bits 0.
- R7: A write to 0x1100 sets cop_busreq to req_wdata[8], and a write to 0x1200 sets cop_enable to req_wdata[8]. The low byte is ignored.
- R8: A write to 0x4000 sets the first key flag to whether the word equals 0x5345, and a write to 0x4002 sets the second to whether it equals 0x4741. video_unlocked is 1 only while both flags are set, so a later mismatching write clears it.
- R9: A write to 0x4100 sets rom_enable to req_wdata[8].
- R10: Address bit 0 is ignored, so an odd offset behaves as the even offset below it.
- R11: Offsets that are not listed read as 0 (this includes the write-only ones), and writes to them change no output.
- R12: Without a read request rd_valid stays 0. Without a write request no port strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Offset within the I/O window |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 16 | Registered read data |
| strap_export | input | 1 | 1 = export region |
| strap_pal | input | 1 | 1 = PAL timing |
| strap_no_exp | input | 1 | 1 = no expansion unit attached |
| strap_version | input | 4 | Hardware version |
| port_data_in | input | 24 | Data bytes of ports 0..2 |
| port_ctrl_in | input | 24 | Control bytes of ports 0..2 |
| port_data_we | output | 3 | Per-port data write strobe |
| port_ctrl_we | output | 3 | Per-port control write strobe |
| port_wdata | output | 8 | Byte forwarded with a strobe |
| cop_grant | input | 1 | Coprocessor bus granted |
| cop_busreq | output | 1 | Coprocessor bus request |
| cop_enable | output | 1 | Coprocessor reset release |
| rom_enable | output | 1 | 1 = cartridge selected over boot ROM |
| video_unlocked | output | 1 | Both key halves written correctly |

## Verification
The status byte is read under two complementary strap settings, so a swapped or stuck bit shows up. Port bytes are distinct per port and per register type, which exposes a wrong index or a data/control mix-up. The key sequence includes an off-by-one value after a correct unlock, which separates an exact match from a latch that only sets. Odd-address aliases, unlisted offsets and upper-byte-only control writes show whether bit 0 is ignored and whether the control bit is taken from the right lane.

// File: rtl/sysio_pkg.sv
package sysio_pkg;
  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_PDATA,
    SEL_PCTRL,
    SEL_GRANT,
    SEL_COPRST,
    SEL_KEY_HI,
    SEL_KEY_LO,
    SEL_BOOTSW
  } sel_e;
endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
  import sysio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_PORTS = 3,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int WA_W = ADDR_W - 1;
  localparam logic [WA_W-1:0] W_STATUS = '0;
  localparam int DATA_BASE = 1;
  localparam int CTRL_BASE = 4;
  localparam logic [WA_W-1:0] W_GRANT  = WA_W'(16'h1100 >> 1);
  localparam logic [WA_W-1:0] W_COPRST = WA_W'(16'h1200 >> 1);
  localparam logic [WA_W-1:0] W_KEY_HI = WA_W'(16'h4000 >> 1);
  localparam logic [WA_W-1:0] W_KEY_LO = WA_W'(16'h4002 >> 1);
  localparam logic [WA_W-1:0] W_BOOTSW = WA_W'(16'h4100 >> 1);

  logic [WA_W-1:0] w;
  assign w = addr[ADDR_W-1:1];

  logic [NUM_PORTS-1:0] hit_d, hit_c;
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_hit
    assign hit_d[g] = (w == WA_W'(DATA_BASE + g));
    assign hit_c[g] = (w == WA_W'(CTRL_BASE + g));
  end

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (hit_d[i] || hit_c[i]) idx = IDX_W'(i);
    end
    if (w == W_STATUS)      sel = SEL_STATUS;
    else if (|hit_d)        sel = SEL_PDATA;
    else if (|hit_c)        sel = SEL_PCTRL;
    else if (w == W_GRANT)  sel = SEL_GRANT;
    else if (w == W_COPRST) sel = SEL_COPRST;
    else if (w == W_KEY_HI) sel = SEL_KEY_HI;
    else if (w == W_KEY_LO) sel = SEL_KEY_LO;
    else if (w == W_BOOTSW) sel = SEL_BOOTSW;
  end
endmodule

// File: rtl/sysio_portfwd.sv
module sysio_portfwd
  import sysio_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  sel_e                 sel,
  input  logic [IDX_W-1:0]     idx,
  input  logic [PORT_W-1:0]    wbyte,
  output logic [NUM_PORTS-1:0] port_data_we,
  output logic [NUM_PORTS-1:0] port_ctrl_we,
  output logic [PORT_W-1:0]    port_wdata
);
  logic [NUM_PORTS-1:0] nxt_d, nxt_c;
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_strobe
    assign nxt_d[g] = wr_en && (sel == SEL_PDATA) && (idx == IDX_W'(g));
    assign nxt_c[g] = wr_en && (sel == SEL_PCTRL) && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_data_we <= '0;
      port_ctrl_we <= '0;
      port_wdata   <= '0;
    end else begin
      port_data_we <= nxt_d;
      port_ctrl_we <= nxt_c;
      if (wr_en) port_wdata <= wbyte;
    end
  end

  // R5: a port write is forwarded in the next cycle
  a_r5_data_fwd: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_PDATA) |=> (|port_data_we && port_wdata == $past(wbyte)));
  a_r5_ctrl_fwd: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_PCTRL) |=> (|port_ctrl_we && port_wdata == $past(wbyte)));
  // R12: no write, no strobe
  a_r12_quiet: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (port_data_we == '0 && port_ctrl_we == '0));
endmodule

// File: rtl/sysio_secure.sv
module sysio_secure
  import sysio_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          CTRL_BIT = 8,
  parameter logic [15:0] KEY_HI   = 16'h5345,
  parameter logic [15:0] KEY_LO   = 16'h4741
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              cop_busreq,
  output logic              cop_enable,
  output logic              rom_enable,
  output logic              video_unlocked
);
  logic key_hi_ok, key_lo_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cop_busreq <= 1'b0;
      cop_enable <= 1'b0;
      rom_enable <= 1'b0;
      key_hi_ok  <= 1'b0;
      key_lo_ok  <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_GRANT:  cop_busreq <= wdata[CTRL_BIT];
        SEL_COPRST: cop_enable <= wdata[CTRL_BIT];
        SEL_BOOTSW: rom_enable <= wdata[CTRL_BIT];
        SEL_KEY_HI: key_hi_ok  <= (wdata == DATA_W'(KEY_HI));
        SEL_KEY_LO: key_lo_ok  <= (wdata == DATA_W'(KEY_LO));
        default: ;
      endcase
    end
  end

  assign video_unlocked = key_hi_ok & key_lo_ok;

  // R7: bus request follows the written control bit
  a_r7_busreq: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_GRANT) |=> (cop_busreq == $past(wdata[CTRL_BIT])));
  // R8: any mismatching key half locks
  a_r8_mismatch_locks: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((sel == SEL_KEY_HI && wdata != DATA_W'(KEY_HI)) ||
               (sel == SEL_KEY_LO && wdata != DATA_W'(KEY_LO)))) |=> !video_unlocked);
  // R9: rom select only moves on its own write
  a_r9_rom_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_BOOTSW) |=> $stable(rom_enable));
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int VER_W     = 4,
  parameter int CTRL_BIT  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        strap_export,
  input  logic                        strap_pal,
  input  logic                        strap_no_exp,
  input  logic [VER_W-1:0]            strap_version,
  input  logic [NUM_PORTS*PORT_W-1:0] port_data_in,
  input  logic [NUM_PORTS*PORT_W-1:0] port_ctrl_in,
  output logic [NUM_PORTS-1:0]        port_data_we,
  output logic [NUM_PORTS-1:0]        port_ctrl_we,
  output logic [PORT_W-1:0]           port_wdata,
  input  logic                        cop_grant,
  output logic                        cop_busreq,
  output logic                        cop_enable,
  output logic                        rom_enable,
  output logic                        video_unlocked
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic             wr_en, rd_en;
  logic [DATA_W-1:0] rd_next;
  logic [7:0]       status_byte;

  assign wr_en = req_valid &  req_write;
  assign rd_en = req_valid & ~req_write;

  sysio_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .sel(sel), .idx(idx)
  );

  sysio_portfwd #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .IDX_W(IDX_W)) u_fwd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .idx(idx),
    .wbyte(req_wdata[PORT_W-1:0]),
    .port_data_we(port_data_we), .port_ctrl_we(port_ctrl_we), .port_wdata(port_wdata)
  );

  sysio_secure #(.DATA_W(DATA_W), .CTRL_BIT(CTRL_BIT)) u_sec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(req_wdata),
    .cop_busreq(cop_busreq), .cop_enable(cop_enable),
    .rom_enable(rom_enable), .video_unlocked(video_unlocked)
  );

  always_comb begin
    status_byte = '0;
    status_byte[VER_W-1:0] = strap_version;
    status_byte[7] = strap_export;
    status_byte[6] = strap_pal;
    status_byte[5] = strap_no_exp;
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_STATUS: rd_next = DATA_W'(status_byte);
      SEL_PDATA:  rd_next = DATA_W'(port_data_in[idx*PORT_W +: PORT_W]);
      SEL_PCTRL:  rd_next = DATA_W'(port_ctrl_in[idx*PORT_W +: PORT_W]);
      SEL_GRANT:  rd_next[CTRL_BIT] = ~cop_grant;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R2: read data is valid one cycle after the request
  a_r2_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R12: no read request, no read valid
  a_r12_no_rd: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R6: grant status read returns inverted grant in the control bit
  a_r6_grant_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_GRANT) |=> (rd_data[CTRL_BIT] == !$past(cop_grant)));
endmodule

// File: tb/tb_sysio_regs.sv
module tb_sysio_regs;
  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic rd_valid;
  logic [15:0] rd_data;
  logic strap_export, strap_pal, strap_no_exp;
  logic [3:0] strap_version;
  logic [23:0] port_data_in, port_ctrl_in;
  logic [2:0] port_data_we, port_ctrl_we;
  logic [7:0] port_wdata;
  logic cop_grant, cop_busreq, cop_enable, rom_enable, video_unlocked;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sysio_regs dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .strap_export(strap_export), .strap_pal(strap_pal), .strap_no_exp(strap_no_exp),
    .strap_version(strap_version), .port_data_in(port_data_in), .port_ctrl_in(port_ctrl_in),
    .port_data_we(port_data_we), .port_ctrl_we(port_ctrl_we), .port_wdata(port_wdata),
    .cop_grant(cop_grant), .cop_busreq(cop_busreq), .cop_enable(cop_enable),
    .rom_enable(rom_enable), .video_unlocked(video_unlocked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [15:0] a, input logic [15:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
    check(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset;
    check("R1 rom_enable", 32'(rom_enable), 0);
    check("R1 video_unlocked", 32'(video_unlocked), 0);
    check("R1 busreq/enable", {30'd0, cop_busreq, cop_enable}, 0);
    check("R1 strobes", {26'd0, port_data_we, port_ctrl_we}, 0);
    check("R1 rd_valid", 32'(rd_valid), 0);
  endtask

  task automatic t_status;
    strap_export = 1; strap_pal = 0; strap_no_exp = 1; strap_version = 4'h2;
    rd_check("R2 status A", 16'h0000, 16'h00A2);
    strap_export = 0; strap_pal = 1; strap_no_exp = 0; strap_version = 4'hD;
    rd_check("R2 status B", 16'h0001, 16'h004D);
    @(negedge clk);
    check("R12 rd_valid idle", 32'(rd_valid), 0);
  endtask

  task automatic t_port_read;
    port_data_in = 24'h332211;
    port_ctrl_in = 24'h665544;
    rd_check("R3 port0 data", 16'h0002, 16'h0011);
    rd_check("R3 R10 port1 data odd", 16'h0005, 16'h0022);
    rd_check("R3 port2 data", 16'h0006, 16'h0033);
    rd_check("R4 port0 ctrl", 16'h0008, 16'h0044);
    rd_check("R4 port1 ctrl", 16'h000A, 16'h0055);
    rd_check("R4 R10 port2 ctrl odd", 16'h000D, 16'h0066);
  endtask

  task automatic t_port_write;
    wr(16'h0004, 16'hFFA5);
    check("R5 data strobe", 32'(port_data_we), 32'b010);
    check("R5 ctrl quiet", 32'(port_ctrl_we), 0);
    check("R5 wdata", 32'(port_wdata), 32'hA5);
    @(negedge clk);
    check("R5 R12 single pulse", {26'd0, port_data_we, port_ctrl_we}, 0);
    wr(16'h000C, 16'h003C);
    check("R5 ctrl strobe", 32'(port_ctrl_we), 32'b100);
    check("R5 ctrl wdata", 32'(port_wdata), 32'h3C);
  endtask

  task automatic t_coproc;
    cop_grant = 0;
    rd_check("R6 grant low", 16'h1100, 16'h0100);
    cop_grant = 1;
    rd_check("R6 grant high", 16'h1101, 16'h0000);
    wr(16'h1100, 16'h0100);
    check("R7 busreq set", 32'(cop_busreq), 1);
    wr(16'h1200, 16'h0100);
    check("R7 enable set", 32'(cop_enable), 1);
    wr(16'h1100, 16'h00FF);
    check("R7 busreq low byte ignored", 32'(cop_busreq), 0);
    check("R7 enable kept", 32'(cop_enable), 1);
  endtask

  task automatic t_unlock;
    wr(16'h4000, 16'h5345);
    check("R8 half key", 32'(video_unlocked), 0);
    wr(16'h4003, 16'h4741);
    check("R8 R10 full key", 32'(video_unlocked), 1);
    wr(16'h4000, 16'h5346);
    check("R8 mismatch relocks", 32'(video_unlocked), 0);
    wr(16'h4000, 16'h5345);
    check("R8 relock restored", 32'(video_unlocked), 1);
  endtask

  task automatic t_rom;
    wr(16'h4101, 16'h0100);
    check("R9 R10 rom on", 32'(rom_enable), 1);
    wr(16'h4004, 16'h0000);
    check("R11 rom unchanged", 32'(rom_enable), 1);
    check("R11 unlock unchanged", 32'(video_unlocked), 1);
    check("R11 busreq unchanged", 32'(cop_busreq), 0);
    rd_check("R11 unlisted read", 16'h000E, 16'h0000);
    rd_check("R11 key reads zero", 16'h4000, 16'h0000);
    wr(16'h4100, 16'h00FF);
    check("R9 rom off", 32'(rom_enable), 0);
  endtask

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    strap_export = 0; strap_pal = 0; strap_no_exp = 0; strap_version = '0;
    port_data_in = '0; port_ctrl_in = '0; cop_grant = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_status();
    t_port_read();
    t_port_write();
    t_coproc();
    t_unlock();
    t_rom();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule